// File: doc/BRIEF.md
# Single-Level Page Table Address Translator

This block turns a virtual address into a physical address by reading one entry of a flat page table kept in memory. A requester presents a virtual address and the kind of access it intends (read, write or execute). The block splits the address into a virtual page number and a page offset. It adds the page number, scaled by the entry size, to a table base input, and issues a single read on a simple memory request/response port.

When the entry returns, the block looks at its present bit and its two-bit permission field. If the page is present and the access is allowed, the block returns the physical page number from the entry joined with the untouched page offset. Otherwise it returns a fault, which is either "not present" or "protection". The block only reports faults and does not service them. Only one translation is in flight at a time, and a new request is refused until the previous answer has been taken.

Top module: `vpt_xlate`

## Requirements
- R1: After reset the block is idle, with req_ready high and resp_valid and mem_req_valid low; a reset in mid-translation returns it to this state.
- R2: The read address is pt_base + VPN * PTE_BYTES, where VPN = req_va[VA_W-1:OFS_W]. Exactly one read is issued per request, and the address is held stable while mem_req_ready is low.
- R3: From acceptance until the response is taken, req_ready stays low, and a request presented during that time is ignored (no further read is issued afterwards).
- R4: Entry layout: bit 0 is the present bit, bits [2:1] are the permission field, and bits [PPN_LSB+PPN_W-1:PPN_LSB] are the physical page number. All other bits are ignored.
- R5: For a present entry whose permission allows the access, resp_pa = {PPN, req_va[OFS_W-1:0]} and resp_fault = 0.
- R6: An entry with the present bit clear gives resp_fault = 1, resp_fault_type = 0 and resp_pa = 0, whatever its permission field holds.
- R7: Permission codes are 00 read-only, 01 read/write, 10 execute-only and 11 read/write/execute. Access codes are 00 read, 01 write, 10 execute and 11 reserved. A read is allowed by 00, 01 and 11. A write is allowed by 01 and 11. An execute is allowed by 10 and 11. The reserved access code is never allowed.
- R8: A present entry that denies the access gives resp_fault = 1, resp_fault_type = 1 and resp_pa = 0.
- R9: resp_valid and all response fields stay stable until resp_ready is seen high.
- R10: mem_req_valid rises on the cycle after the request is accepted. resp_valid rises on the cycle after mem_resp_valid is seen while waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_base | input | PA_W | Byte address of the page table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | VA_W | Virtual address to translate |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 reserved |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_resp_valid | input | 1 | Entry data returned |
| mem_resp_data | input | PTE_W | Entry contents |
| resp_valid | output | 1 | Translation result present |
| resp_ready | input | 1 | Requester takes the result |
| resp_pa | output | PA_W | Physical address, zero on fault |
| resp_fault | output | 1 | Translation failed |
| resp_fault_type | output | 1 | 0 not present, 1 protection |

## Verification
Every virtual page number of a reduced configuration is translated with all four access codes. The entries are built arithmetically, so that the present bit, the permission code and the page number vary independently. This separates an address-scaling error from an offset error, a permission-table error from a fault-priority error, and a wrong fault kind from a wrong page number. Each translation also varies the memory and response stall lengths, and offers an extra request while the block is busy, which exposes handshake holding errors and double acceptance. A reset in the middle of a translation checks the return to idle.

// File: rtl/vpt_pkg.sv
package vpt_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_EXEC  = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_e;

   typedef enum logic [1:0] {
      PERM_RO  = 2'b00,
      PERM_RW  = 2'b01,
      PERM_XO  = 2'b10,
      PERM_RWX = 2'b11
   } perm_e;

   localparam logic FT_ABSENT = 1'b0;
   localparam logic FT_PROT   = 1'b1;

   localparam int PTE_PRESENT_BIT = 0;
   localparam int PTE_PERM_LSB    = 1;

   function automatic logic perm_allows(input perm_e perm, input acc_e acc);
      logic ok;
      case (acc)
         ACC_READ:  ok = (perm != PERM_XO);
         ACC_WRITE: ok = (perm == PERM_RW) || (perm == PERM_RWX);
         ACC_EXEC:  ok = (perm == PERM_XO) || (perm == PERM_RWX);
         default:   ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/vpt_addr_gen.sv
module vpt_addr_gen #(
   parameter int VA_W      = 40,
   parameter int OFS_W     = 14,
   parameter int PA_W      = 36,
   parameter int PTE_BYTES = 8
) (
   input  logic [VA_W-1:0] va,
   input  logic [PA_W-1:0] base,
   output logic [PA_W-1:0] entry_addr
);
   localparam int VPN_W = VA_W - OFS_W;
   localparam int LG_SZ = $clog2(PTE_BYTES);
   localparam int SC_W  = VPN_W + LG_SZ;

   logic [VPN_W-1:0] vpn;
   logic [SC_W-1:0]  scaled;

   assign vpn = va[VA_W-1:OFS_W];

   generate
      if (LG_SZ == 0) begin : g_byte_entry
         assign scaled = vpn;
      end else begin : g_wide_entry
         assign scaled = {vpn, {LG_SZ{1'b0}}};
      end
      if ((1 << LG_SZ) != PTE_BYTES) begin : g_bad_size
         $error("PTE_BYTES must be a power of two");
      end
   endgenerate

   generate
      if (SC_W >= PA_W) begin : g_trunc
         assign entry_addr = base + scaled[PA_W-1:0];
      end else begin : g_ext
         assign entry_addr = base + {{(PA_W-SC_W){1'b0}}, scaled};
      end
   endgenerate

endmodule

// File: rtl/vpt_pte_check.sv
module vpt_pte_check
   import vpt_pkg::*;
#(
   parameter int PTE_W   = 64,
   parameter int PA_W    = 36,
   parameter int OFS_W   = 14,
   parameter int PPN_LSB = 10
) (
   input  logic [PTE_W-1:0] pte,
   input  logic [1:0]       acc,
   input  logic [OFS_W-1:0] ofs,
   output logic [PA_W-1:0]  pa,
   output logic             fault,
   output logic             fault_type
);
   localparam int PPN_W = PA_W - OFS_W;

   logic             present;
   perm_e            perm;
   logic [PPN_W-1:0] ppn;
   logic             allowed;

   assign present = pte[PTE_PRESENT_BIT];
   assign perm    = perm_e'(pte[PTE_PERM_LSB +: 2]);
   assign ppn     = pte[PPN_LSB +: PPN_W];
   assign allowed = perm_allows(perm, acc_e'(acc));

   always_comb begin
      fault      = 1'b0;
      fault_type = FT_ABSENT;
      pa         = {ppn, ofs};
      if (!present) begin
         fault      = 1'b1;
         fault_type = FT_ABSENT;
         pa         = '0;
      end else if (!allowed) begin
         fault      = 1'b1;
         fault_type = FT_PROT;
         pa         = '0;
      end
   end

   always_comb begin
      a_absent_wins_r6: assert (present || (fault && fault_type == FT_ABSENT));
   end

endmodule

// File: rtl/vpt_ctrl.sv
module vpt_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic mem_req_ready,
   input  logic mem_resp_valid,
   input  logic resp_ready,
   output logic req_ready,
   output logic mem_req_valid,
   output logic resp_valid,
   output logic take_req,
   output logic take_resp,
   output logic waiting
);
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT = 2'd2,
      ST_DONE = 2'd3
   } st_e;

   st_e st, st_nx;

   assign req_ready     = (st == ST_IDLE);
   assign mem_req_valid = (st == ST_ISSUE);
   assign waiting       = (st == ST_WAIT);
   assign resp_valid    = (st == ST_DONE);
   assign take_req      = req_ready && req_valid;
   assign take_resp     = waiting && mem_resp_valid;

   always_comb begin
      st_nx = st;
      case (st)
         ST_IDLE:  if (req_valid)      st_nx = ST_ISSUE;
         ST_ISSUE: if (mem_req_ready)  st_nx = ST_WAIT;
         ST_WAIT:  if (mem_resp_valid) st_nx = ST_DONE;
         ST_DONE:  if (resp_ready)     st_nx = ST_IDLE;
         default:                      st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nx;
   end

   p_issue_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      take_req |=> mem_req_valid);
   p_resp_after_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
      take_resp |=> resp_valid);
   p_single_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid || waiting || resp_valid) |-> !req_ready);

endmodule

// File: rtl/vpt_xlate.sv
module vpt_xlate #(
   parameter int VA_W      = 40,
   parameter int OFS_W     = 14,
   parameter int PA_W      = 36,
   parameter int PTE_W     = 64,
   parameter int PTE_BYTES = 8,
   parameter int PPN_LSB   = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PA_W-1:0]  pt_base,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_va,
   input  logic [1:0]       req_acc,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [PA_W-1:0]  mem_req_addr,
   input  logic             mem_resp_valid,
   input  logic [PTE_W-1:0] mem_resp_data,
   output logic             resp_valid,
   input  logic             resp_ready,
   output logic [PA_W-1:0]  resp_pa,
   output logic             resp_fault,
   output logic             resp_fault_type
);
   localparam int PPN_W = PA_W - OFS_W;

   generate
      if (OFS_W < 1 || OFS_W >= VA_W) begin : g_bad_ofs
         $error("OFS_W must lie between 1 and VA_W-1");
      end
      if (PPN_W < 1) begin : g_bad_pa
         $error("PA_W must exceed OFS_W");
      end
      if (PPN_LSB < 3 || PPN_LSB + PPN_W > PTE_W) begin : g_bad_pte
         $error("PPN field must sit above the flag bits and inside the entry");
      end
   endgenerate

   logic             take_req, take_resp, waiting;
   logic [PA_W-1:0]  addr_nx;
   logic [PA_W-1:0]  addr_q;
   logic [1:0]       acc_q;
   logic [OFS_W-1:0] ofs_q;
   logic [PA_W-1:0]  pa_nx, pa_q;
   logic             flt_nx, flt_q, ft_nx, ft_q;

   vpt_ctrl u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .mem_req_ready  (mem_req_ready),
      .mem_resp_valid (mem_resp_valid),
      .resp_ready     (resp_ready),
      .req_ready      (req_ready),
      .mem_req_valid  (mem_req_valid),
      .resp_valid     (resp_valid),
      .take_req       (take_req),
      .take_resp      (take_resp),
      .waiting        (waiting)
   );

   vpt_addr_gen #(
      .VA_W(VA_W), .OFS_W(OFS_W), .PA_W(PA_W), .PTE_BYTES(PTE_BYTES)
   ) u_addr (
      .va         (req_va),
      .base       (pt_base),
      .entry_addr (addr_nx)
   );

   vpt_pte_check #(
      .PTE_W(PTE_W), .PA_W(PA_W), .OFS_W(OFS_W), .PPN_LSB(PPN_LSB)
   ) u_chk (
      .pte        (mem_resp_data),
      .acc        (acc_q),
      .ofs        (ofs_q),
      .pa         (pa_nx),
      .fault      (flt_nx),
      .fault_type (ft_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         acc_q  <= '0;
         ofs_q  <= '0;
      end else if (take_req) begin
         addr_q <= addr_nx;
         acc_q  <= req_acc;
         ofs_q  <= req_va[OFS_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pa_q  <= '0;
         flt_q <= 1'b0;
         ft_q  <= 1'b0;
      end else if (take_resp) begin
         pa_q  <= pa_nx;
         flt_q <= flt_nx;
         ft_q  <= ft_nx;
      end
   end

   assign mem_req_addr    = addr_q;
   assign resp_pa         = pa_q;
   assign resp_fault      = flt_q;
   assign resp_fault_type = ft_q;

   p_mem_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
   p_resp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && !resp_ready |=> resp_valid && $stable(resp_pa)
         && $stable(resp_fault) && $stable(resp_fault_type));
   p_fault_zero_pa_r8: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && resp_fault |-> resp_pa == '0);
   p_offset_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && !resp_fault |-> resp_pa[OFS_W-1:0] == ofs_q);
   p_no_stray_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> !mem_req_valid && !waiting);

endmodule

// File: tb/vpt_xlate_test.sv
module vpt_xlate_test;
   localparam int CLK_PERIOD = 10;
   localparam int VA_W = 12, OFS_W = 4, PA_W = 10, PTE_W = 16, PTE_BYTES = 2, PPN_LSB = 8;
   localparam int PPN_W = PA_W - OFS_W;
   localparam int WATCHDOG = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [PA_W-1:0] pt_base = 10'h106;
   logic req_valid = 1'b0, req_ready;
   logic [VA_W-1:0] req_va = '0;
   logic [1:0] req_acc = '0;
   logic mem_req_valid, mem_req_ready = 1'b0;
   logic [PA_W-1:0] mem_req_addr;
   logic mem_resp_valid = 1'b0;
   logic [PTE_W-1:0] mem_resp_data = '0;
   logic resp_valid, resp_ready = 1'b0;
   logic [PA_W-1:0] resp_pa;
   logic resp_fault, resp_fault_type;

   int checks = 0, failures = 0, cycles = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vpt_xlate #(.VA_W(VA_W), .OFS_W(OFS_W), .PA_W(PA_W), .PTE_W(PTE_W),
               .PTE_BYTES(PTE_BYTES), .PPN_LSB(PPN_LSB)) uut (
      .clk(clk), .rst_n(rst_n), .pt_base(pt_base),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_acc(req_acc),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
      .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_pa(resp_pa),
      .resp_fault(resp_fault), .resp_fault_type(resp_fault_type));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [PTE_W-1:0] make_pte(input int v);
      logic [PTE_W-1:0] p;
      logic [1:0] perm;
      logic [PPN_W-1:0] ppn;
      perm = 2'(v) ^ 2'(v >> 2);
      ppn  = PPN_W'(v * 5 + 9);
      p = '0;
      p[0] = ((v % 7) != 3);
      p[2:1] = perm;
      p[7:3] = 5'(v);
      p[PPN_LSB +: PPN_W] = ppn;
      p[15:14] = 2'b11;
      return p;
   endfunction

   // R7 permission table, written independently of the design
   function automatic bit allowed(input logic [1:0] perm, input logic [1:0] acc);
      case (acc)
         2'b00: return perm inside {2'b00, 2'b01, 2'b11};
         2'b01: return perm inside {2'b01, 2'b11};
         2'b10: return perm inside {2'b10, 2'b11};
         default: return 1'b0;
      endcase
   endfunction

   task automatic xlate(input int v, input int a, input int d1, input int d2, input int d3);
      logic [VA_W-1:0] va;
      logic [PTE_W-1:0] pte;
      logic [PA_W-1:0] exp_addr, exp_pa;
      bit exp_f, exp_t;
      va = {8'(v), 4'(v + a * 3)};
      pte = make_pte(v);
      exp_addr = pt_base + PA_W'(v * PTE_BYTES);
      if (!pte[0]) begin exp_f = 1; exp_t = 0; exp_pa = '0; end
      else if (!allowed(pte[2:1], 2'(a))) begin exp_f = 1; exp_t = 1; exp_pa = '0; end
      else begin exp_f = 0; exp_t = 0; exp_pa = {pte[PPN_LSB +: PPN_W], va[3:0]}; end

      chk(req_ready === 1'b1, "R3 ready when idle", req_ready, 1);
      req_valid = 1'b1; req_va = va; req_acc = 2'(a);
      @(negedge clk);
      req_valid = 1'b0;
      chk(mem_req_valid === 1'b1, "R10 read issued next cycle", mem_req_valid, 1);
      chk(mem_req_addr === exp_addr, "R2 entry address", mem_req_addr, exp_addr);
      for (int i = 0; i < d1; i++) begin
         @(negedge clk);
         chk(mem_req_valid === 1'b1 && mem_req_addr === exp_addr, "R2 read held",
             mem_req_addr, exp_addr);
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk(mem_req_valid === 1'b0, "R2 one read only", mem_req_valid, 0);
      for (int i = 0; i < d2; i++) begin
         @(negedge clk);
         chk(resp_valid === 1'b0 && req_ready === 1'b0, "R3 busy while waiting", resp_valid, 0);
      end
      mem_resp_valid = 1'b1; mem_resp_data = pte;
      req_valid = 1'b1; req_va = ~va; req_acc = 2'(a + 1);
      @(negedge clk);
      mem_resp_valid = 1'b0; mem_resp_data = '1;
      chk(resp_valid === 1'b1, "R10 response next cycle", resp_valid, 1);
      chk(req_ready === 1'b0, "R3 refuse while result pending", req_ready, 0);
      chk(resp_fault === exp_f, exp_f ? "R8 R6 fault flag" : "R5 no fault", resp_fault, exp_f);
      chk(resp_fault_type === exp_t, exp_t ? "R8 protection kind" : "R6 absent kind",
          resp_fault_type, exp_t);
      chk(resp_pa === exp_pa, exp_f ? "R8 zero address on fault" : "R5 R4 R7 physical address",
          resp_pa, exp_pa);
      for (int i = 0; i < d3; i++) begin
         @(negedge clk);
         chk(resp_valid === 1'b1 && resp_pa === exp_pa && resp_fault === exp_f
             && resp_fault_type === exp_t, "R9 result held", resp_pa, exp_pa);
      end
      resp_ready = 1'b1;
      @(negedge clk);
      resp_ready = 1'b0; req_valid = 1'b0;
      chk(resp_valid === 1'b0 && mem_req_valid === 1'b0, "R3 busy-time request ignored",
          mem_req_valid, 0);
   endtask

   initial begin
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > WATCHDOG) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready === 1'b1 && resp_valid === 1'b0 && mem_req_valid === 1'b0,
          "R1 reset state", {req_ready, resp_valid, mem_req_valid}, 3'b100);
      rst_n = 1'b1;
      @(negedge clk);
      for (int v = 0; v < 256; v++)
         for (int a = 0; a < 4; a++)
            xlate(v, a, v % 3, (v + a) % 4, a % 2);
      // R1: reset in the middle of a translation
      req_valid = 1'b1; req_va = 12'h5A3; req_acc = 2'b00;
      @(negedge clk);
      req_valid = 1'b0;
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk(req_ready === 1'b1 && resp_valid === 1'b0 && mem_req_valid === 1'b0,
          "R1 idle after mid-flight reset", {req_ready, resp_valid, mem_req_valid}, 3'b100);
      @(negedge clk);
      xlate(17, 1, 0, 0, 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule